// File: doc/BRIEF.md
# Triggered Exposure Sequencer

This block runs a sensor's exposure when the exposure start comes from an external trigger and not from the frame timing. While the mode is enabled and no trigger has arrived, it fires the charge-discharge output once in every line and keeps the readout pulse inactive. The image area is therefore held empty until it is needed.

A falling edge on the trigger input passes through a two-flop synchronizer. The block then asks the line timing to restart and restarts its own line position in the same clock. It fires one last discharge pulse in that first line to empty the sensor. It then counts a number of whole lines that is captured at the moment of the trigger, and issues the readout pulse. A frame-memory write-enable pulse of the same timing comes with the readout pulse. The exposure is always a whole number of lines and does not depend on vertical sync. A vertical-halt flag tells the sync generator to freeze its vertical and field outputs for as long as the mode is enabled.

Top module: `trig_exposure_seq`

## Requirements
- R1: While the mode is enabled and idle, `disch_o` is high for DISCH_LEN clocks once every LINE_CLKS clocks, and `read_o` stays low.
- R2: A falling edge on `trig` that is accepted in idle drives `line_rst_o` high for exactly one clock, 3 clocks after the edge. Line position 0 starts in that same clock.
- R3: After an accepted trigger, exactly one discharge pulse occurs before readout. It rises DISCH_START+1 clocks after `line_rst_o`.
- R4: `read_o` rises exactly max(E,1)*LINE_CLKS clocks after `line_rst_o` and stays high for READ_LEN clocks. E is the value of `exp_lines` in the clock when the trigger is accepted, so a later change of `exp_lines` has no effect on that exposure.
- R5: `wen_o` has the same timing as `read_o`.
- R6: `vhalt_o` equals `mode_en` delayed by one clock. It stays high through the whole exposure.
- R7: Trigger edges that arrive during an exposure or a readout are ignored. They produce no `line_rst_o` and do not shift the readout.
- R8: After readout the block is idle again. A discharge pulse rises within LINE_CLKS+1 clocks of the end of readout.
- R9: When `mode_en` is low, the block drops back to idle at once. `disch_o`, `read_o`, `wen_o` and `line_rst_o` stay low and triggers are ignored. A trigger is accepted again once the mode is re-enabled.
- R10: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Enables triggered exposure mode |
| trig | input | 1 | Asynchronous trigger; the falling edge starts an exposure |
| exp_lines | input | EXP_W | Exposure length in whole lines (0 behaves as 1) |
| disch_o | output | 1 | Sensor discharge pulse |
| read_o | output | 1 | Sensor readout pulse |
| wen_o | output | 1 | Frame-memory write enable |
| line_rst_o | output | 1 | One-clock request to reset the horizontal line counter |
| vhalt_o | output | 1 | Vertical-sync halt flag |

## Verification
The bench sweeps every exposure length of a 4-bit count, 0 included, and measures the readout delay from the line reset. A design that counted from the trigger edge instead of the line reset, or that treated 0 as a full wrap of the count, would be off by whole lines or by a fixed number of clocks. Each exposure gets a second trigger in the middle of it or during its readout, and `exp_lines` is rewritten during the count. A design that accepted these would emit a second line reset or move the readout. Dropping the mode part way through an exposure must kill the readout and clear the halt flag. Discharge pulses are counted after the line reset, so a design that kept discharging during exposure would be caught.

// File: rtl/tes_pkg.sv
package tes_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_CLEAR  = 2'd1,
    S_EXPOSE = 2'd2,
    S_READ   = 2'd3
  } tes_state_t;
endpackage

// File: rtl/tes_trig_sync.sv
module tes_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic fall
);
  localparam int N = STAGES + 1;
  logic [N-1:0] q;

  // Idle level is high, so reset to ones to avoid a false edge.
  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= {q[N-2:0], trig};
  end

  assign fall = q[N-1] & ~q[N-2];

  assert_fall_after_high_R2: assert property (@(posedge clk) disable iff (rst)
    fall |-> $past(q[N-2]));
endmodule

// File: rtl/tes_line_timer.sv
module tes_line_timer #(
  parameter int LINE_CLKS   = 780,
  parameter int DISCH_START = 10,
  parameter int DISCH_LEN   = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic line_end,
  output logic disch_win
);
  localparam int PW = $clog2(LINE_CLKS);
  localparam logic [PW-1:0] LAST = PW'(LINE_CLKS - 1);

  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst || clr)       pos <= '0;
    else if (pos == LAST) pos <= '0;
    else                  pos <= pos + 1'b1;
  end

  assign line_end  = (pos == LAST);
  assign disch_win = (int'(pos) >= DISCH_START) &&
                     (int'(pos) < DISCH_START + DISCH_LEN);

  assert_pos_zero_after_clr_R2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pos == '0));
  assert_pos_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    int'(pos) < LINE_CLKS);
endmodule

// File: rtl/tes_expose_fsm.sv
module tes_expose_fsm
  import tes_pkg::*;
#(
  parameter int EXP_W    = 9,
  parameter int READ_LEN = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_en,
  input  logic             fall,
  input  logic             line_end,
  input  logic             disch_win,
  input  logic [EXP_W-1:0] exp_lines,
  output logic             accept,
  output logic             disch_o,
  output logic             read_o,
  output logic             wen_o,
  output logic             line_rst_o,
  output logic             vhalt_o
);
  localparam int RW = $clog2(READ_LEN + 1);
  localparam logic [RW-1:0] RD_LAST = RW'(READ_LEN - 1);
  localparam logic [EXP_W-1:0] ONE = EXP_W'(1);

  tes_state_t       state, state_n;
  logic [EXP_W-1:0] rem, rem_n;
  logic [RW-1:0]    rd, rd_n;

  assign accept = mode_en && (state == S_IDLE) && fall;

  always_comb begin
    state_n = state;
    rem_n   = rem;
    rd_n    = rd;
    case (state)
      S_IDLE: begin
        if (accept) begin
          state_n = S_CLEAR;
          rem_n   = (exp_lines == '0) ? ONE : exp_lines;
        end
      end
      S_CLEAR, S_EXPOSE: begin
        if (line_end) begin
          if (rem == ONE) begin
            state_n = S_READ;
            rd_n    = '0;
          end else begin
            state_n = S_EXPOSE;
            rem_n   = rem - ONE;
          end
        end
      end
      S_READ: begin
        if (rd == RD_LAST) state_n = S_IDLE;
        else               rd_n    = rd + 1'b1;
      end
      default: state_n = S_IDLE;
    endcase
    if (!mode_en) state_n = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      rem        <= '0;
      rd         <= '0;
      disch_o    <= 1'b0;
      read_o     <= 1'b0;
      wen_o      <= 1'b0;
      line_rst_o <= 1'b0;
      vhalt_o    <= 1'b0;
    end else begin
      state      <= state_n;
      rem        <= rem_n;
      rd         <= rd_n;
      disch_o    <= mode_en && disch_win &&
                    ((state == S_IDLE) || (state == S_CLEAR));
      read_o     <= (state_n == S_READ);
      wen_o      <= (state_n == S_READ);
      line_rst_o <= accept;
      vhalt_o    <= mode_en;
    end
  end

  assert_rst_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    line_rst_o |=> !line_rst_o);
  assert_rst_only_from_idle_R7: assert property (@(posedge clk) disable iff (rst)
    line_rst_o |-> ($past(state) == S_IDLE));
  assert_read_after_last_line_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_en && line_end && (rem == ONE) &&
     ((state == S_CLEAR) || (state == S_EXPOSE))) |=> read_o);
  assert_read_len_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_READ) |-> (rd <= RD_LAST));
  assert_no_disch_in_read_R3: assert property (@(posedge clk) disable iff (rst)
    read_o |-> !disch_o);
  assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    !vhalt_o |-> (!disch_o && !read_o && !wen_o && !line_rst_o));
endmodule

// File: rtl/trig_exposure_seq.sv
module trig_exposure_seq #(
  parameter int LINE_CLKS   = 780,
  parameter int DISCH_START = 10,
  parameter int DISCH_LEN   = 40,
  parameter int READ_LEN    = 30,
  parameter int EXP_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_en,
  input  logic             trig,
  input  logic [EXP_W-1:0] exp_lines,
  output logic             disch_o,
  output logic             read_o,
  output logic             wen_o,
  output logic             line_rst_o,
  output logic             vhalt_o
);
  logic fall, accept, line_end, disch_win;

  initial begin
    assert_params_R1: assert (DISCH_START + DISCH_LEN <= LINE_CLKS &&
                              DISCH_LEN > 0 && READ_LEN > 0 && LINE_CLKS > 1);
  end

  tes_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .trig (trig),
    .fall (fall)
  );

  tes_line_timer #(
    .LINE_CLKS   (LINE_CLKS),
    .DISCH_START (DISCH_START),
    .DISCH_LEN   (DISCH_LEN)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clr       (accept),
    .line_end  (line_end),
    .disch_win (disch_win)
  );

  tes_expose_fsm #(
    .EXP_W    (EXP_W),
    .READ_LEN (READ_LEN)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .mode_en    (mode_en),
    .fall       (fall),
    .line_end   (line_end),
    .disch_win  (disch_win),
    .exp_lines  (exp_lines),
    .accept     (accept),
    .disch_o    (disch_o),
    .read_o     (read_o),
    .wen_o      (wen_o),
    .line_rst_o (line_rst_o),
    .vhalt_o    (vhalt_o)
  );

  assert_wen_tracks_read_R5: assert property (@(posedge clk) disable iff (rst)
    wen_o == read_o);
endmodule

// File: tb/sim_trig_exposure_seq.sv
module sim_trig_exposure_seq;
  localparam int L  = 16;
  localparam int DS = 3;
  localparam int DL = 4;
  localparam int RL = 5;
  localparam int EW = 4;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_en = 1'b0;
  logic trig = 1'b1;
  logic [EW-1:0] exp_lines = '0;
  logic disch_o, read_o, wen_o, line_rst_o, vhalt_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trig_exposure_seq #(
    .LINE_CLKS(L), .DISCH_START(DS), .DISCH_LEN(DL),
    .READ_LEN(RL), .EXP_W(EW), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rst(rst), .mode_en(mode_en), .trig(trig),
    .exp_lines(exp_lines), .disch_o(disch_o), .read_o(read_o),
    .wen_o(wen_o), .line_rst_o(line_rst_o), .vhalt_o(vhalt_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // One triggered exposure with exposure setting e.
  task automatic trial(input int e, input int pre);
    int ee = (e == 0) ? 1 : e;
    int rr = -1, nrst = 0, clr_first = -1, nclr = 0;
    int rd_rise = -1, rd_w = 0, wmis = 0, vlow = 0, back = 0;
    int inj = (ee >= 2) ? LAT + L + 2 : LAT + L;
    int endk = LAT + ee * L + RL + 2;
    logic pd = 1'b0;
    exp_lines = EW'(e);
    repeat (pre) @(posedge clk);
    #1 trig = 1'b0;
    for (int k = 1; k <= endk; k++) begin
      @(posedge clk);
      #1;
      if (k == 4)       trig = 1'b1;
      if (k == 10)      exp_lines = ~EW'(e);
      if (k == inj)     trig = 1'b0;
      if (k == inj + 4) trig = 1'b1;
      @(negedge clk);
      if (line_rst_o) begin
        nrst++;
        if (rr < 0) rr = k;
      end
      if (rr >= 0 && k > rr && rd_rise < 0 && disch_o && !pd) begin
        nclr++;
        if (clr_first < 0) clr_first = k;
      end
      pd = disch_o;
      if (read_o) begin
        rd_w++;
        if (rd_rise < 0) rd_rise = k;
      end
      if (wen_o != read_o) wmis++;
      if (!vhalt_o) vlow++;
    end
    chk(rr == LAT, $sformatf("R2 line reset latency e=%0d", e), rr, LAT);
    chk(nrst == 1, $sformatf("R7 line resets per exposure e=%0d", e), nrst, 1);
    chk(nclr == 1, $sformatf("R3 clear pulse count e=%0d", e), nclr, 1);
    chk(clr_first == LAT + DS + 1, $sformatf("R3 clear pulse position e=%0d", e),
        clr_first, LAT + DS + 1);
    chk(rd_rise == LAT + ee * L, $sformatf("R4 readout delay e=%0d", e),
        rd_rise, LAT + ee * L);
    chk(rd_w == RL, $sformatf("R4 readout width e=%0d", e), rd_w, RL);
    chk(wmis == 0, $sformatf("R5 write enable mismatches e=%0d", e), wmis, 0);
    chk(vlow == 0, $sformatf("R6 halt low cycles e=%0d", e), vlow, 0);
    for (int k = 0; k < L + 1; k++) begin
      @(negedge clk);
      if (disch_o && !pd) back = 1;
      pd = disch_o;
    end
    chk(back == 1, $sformatf("R8 discharge resumes e=%0d", e), back, 1);
  endtask

  initial begin
    int r1 = -1, r2 = -1, r3 = -1, w = 0, rdh = 0;
    logic pd = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!disch_o && !read_o && !wen_o && !line_rst_o && !vhalt_o,
        "R10 reset state", {disch_o, read_o, wen_o, line_rst_o, vhalt_o}, 0);

    // Mode off: triggers ignored, outputs quiet
    for (int k = 0; k < 3 * L; k++) begin
      @(posedge clk);
      #1;
      if (k == 5) trig = 1'b0;
      if (k == 9) trig = 1'b1;
      @(negedge clk);
      w += disch_o + read_o + wen_o + line_rst_o + vhalt_o;
    end
    chk(w == 0, "R9 outputs while mode off", w, 0);

    @(posedge clk);
    #1 mode_en = 1'b1;
    @(negedge clk);
    chk(vhalt_o == 1'b0, "R6 halt lags enable", vhalt_o, 0);
    @(negedge clk);
    chk(vhalt_o == 1'b1, "R6 halt follows enable", vhalt_o, 1);

    // Idle discharge: period and width
    w = 0;
    for (int k = 0; k < 4 * L; k++) begin
      @(negedge clk);
      if (disch_o && !pd) begin
        if (r1 < 0) r1 = k;
        else if (r2 < 0) r2 = k;
        else if (r3 < 0) r3 = k;
      end
      if (disch_o && r1 >= 0 && r2 < 0) w++;
      if (read_o || wen_o) rdh++;
      pd = disch_o;
    end
    chk(r2 - r1 == L, "R1 idle discharge period", r2 - r1, L);
    chk(r3 - r2 == L, "R1 idle discharge period 2", r3 - r2, L);
    chk(w == DL, "R1 idle discharge width", w, DL);
    chk(rdh == 0, "R1 readout low in idle", rdh, 0);

    // Full sweep of exposure settings
    for (int e = 0; e < (1 << EW); e++) trial(e, 3 + (e * 5) % 13);

    // Abort by dropping the mode part way through an exposure
    begin
      int q = 0;
      exp_lines = EW'(8);
      @(posedge clk);
      #1 trig = 1'b0;
      for (int k = 1; k <= LAT + 20; k++) begin
        @(posedge clk);
        #1;
        if (k == 4) trig = 1'b1;
      end
      mode_en = 1'b0;
      @(negedge clk);
      chk(vhalt_o == 1'b1, "R6 halt one clock after disable", vhalt_o, 1);
      @(posedge clk);
      @(negedge clk);
      chk(vhalt_o == 1'b0, "R9 halt released", vhalt_o, 0);
      for (int k = 0; k < 10 * L; k++) begin
        @(posedge clk);
        #1;
        if (k == 7)  trig = 1'b0;
        if (k == 11) trig = 1'b1;
        @(negedge clk);
        q += disch_o + read_o + wen_o + line_rst_o;
      end
      chk(q == 0, "R9 no activity after abort", q, 0);
      @(posedge clk);
      #1 mode_en = 1'b1;
      trial(2, 5);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule